// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block sits between a host bus and a PS/2 keyboard line. It owns the host-visible buffers of the keyboard controller. Bytes that arrive serially from the keyboard are assembled, checked for odd parity and placed in an 8-bit output buffer. The host reads that buffer at the data port (60h). Loading the buffer raises an interrupt, and a data-port read clears it.

The host writes one input buffer through either port. A write at the data port (60h) marks the byte as data, and a write at the command port (64h) marks it as a command. The byte, its kind and a full flag go to the consumer, which acknowledges with a pulse. A read at the command port returns a status byte and does not change any state. The host port select is a single bit: 0 selects 60h and 1 selects 64h. A read or write strobe lasts one clock.

Top module: `kbd_host_if`

## Requirements
- R1: After reset, the output buffer and the input buffer are both empty, irq is low, ib_full is low, and the status byte reads 00h.
- R2: A write with host_sel_cmd=0 (port 60h) loads ib_data, sets ib_full, and clears ib_is_cmd.
- R3: A write with host_sel_cmd=1 (port 64h) loads ib_data, sets ib_full, and sets ib_is_cmd.
- R4: A one-cycle ib_ack pulse clears ib_full. When a write falls in the same cycle as ib_ack, ib_full stays set.
- R5: A frame is sampled on falling edges of kb_clk. It consists of a start bit of 0, then 8 data bits with the LSB first, then an odd parity bit, then a stop bit of 1. A complete frame loads the output buffer, which a read at port 60h returns, and sets status bit 0.
- R6: irq is high exactly while the output buffer is full. A read at port 60h empties the buffer and drops irq. A read at port 64h leaves both unchanged.
- R7: A frame with wrong parity is still loaded, and it sets status bit 7. The next frame loaded with good parity clears bit 7.
- R8: A frame that completes while the output buffer is full is discarded. The buffer contents and status bit 7 keep their values.
- R9: A frame whose stop bit is 0 is discarded, and the output buffer stays empty.
- R10: When a read at port 60h falls in the same cycle as a frame completion, the read returns the old byte. The new byte is loaded and the buffer stays full.
- R11: The status byte holds output-buffer-full in bit 0, ib_full in bit 1, the command flag (ib_is_cmd) in bit 3, and the parity-error flag in bit 7. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_cmd | input | 1 | Port select: 0 = data port 60h, 1 = command/status port 64h |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | One-cycle host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Output buffer (60h) or status byte (64h) |
| irq | output | 1 | Output-buffer-loaded interrupt, level |
| kb_clk | input | 1 | Device serial clock, asynchronous |
| kb_data | input | 1 | Device serial data, asynchronous |
| ib_ack | input | 1 | Consumer acknowledge, clears ib_full |
| ib_data | output | 8 | Input buffer contents |
| ib_is_cmd | output | 1 | 1 if the last host write was at port 64h |
| ib_full | output | 1 | Input buffer holds an unconsumed byte |

## Verification
Two collisions can occur in a single clock. The first is a host read at port 60h landing in the same cycle as a completed frame. The bench counts the synchroniser and decode registers after the stop-bit falling edge, so that its read strobe meets the load in the fourth clock. It then checks that the old byte was returned, the buffer is still full, and the next read yields the new byte. The second collision is a host write against the consumer acknowledge. The bench drives both in one cycle and requires ib_full to stay set.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] kbd_byte_t;

  // odd parity: data bits plus parity bit hold an odd number of ones
  function automatic logic odd_par_ok(input kbd_byte_t b, input logic p);
    return ^{b, p};
  endfunction

  function automatic kbd_byte_t pack_status(input logic obf, input logic ibf,
                                            input logic cmd, input logic perr);
    kbd_byte_t s;
    s    = '0;
    s[0] = obf;
    s[1] = ibf;
    s[3] = cmd;
    s[7] = perr;
    return s;
  endfunction
endpackage

// File: rtl/kbd_rx_frame.sv
module kbd_rx_frame
  import kbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      kb_clk,
  input  logic      kb_data,
  output logic      done_o,
  output kbd_byte_t byte_o,
  output logic      par_ok_o
);
  localparam int LAST_BIT = BYTE_W + 2;
  localparam int CNT_W    = $clog2(LAST_BIT + 1);

  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_sync[g] <= 1'b1;
        dat_sync[g] <= 1'b1;
      end else if (g == 0) begin
        clk_sync[g] <= kb_clk;
        dat_sync[g] <= kb_data;
      end else begin
        clk_sync[g] <= clk_sync[(g > 0) ? g-1 : 0];
        dat_sync[g] <= dat_sync[(g > 0) ? g-1 : 0];
      end
    end
  end

  logic clk_s, d_s, clk_prev;
  assign clk_s = clk_sync[SYNC_STAGES-1];
  assign d_s   = dat_sync[SYNC_STAGES-1];

  logic fall_evt;
  assign fall_evt = clk_prev & ~clk_s;

  logic [CNT_W-1:0] bit_cnt;
  kbd_byte_t        shreg;
  logic             par_q, done_q;

  logic at_stop, frame_ok_evt;
  assign at_stop      = (bit_cnt == CNT_W'(LAST_BIT));
  assign frame_ok_evt = fall_evt && at_stop && d_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b1;
      bit_cnt  <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      clk_prev <= clk_s;
      done_q   <= frame_ok_evt;
      if (fall_evt) begin
        if (bit_cnt == '0) begin
          if (!d_s) bit_cnt <= CNT_W'(1);
        end else if (bit_cnt <= CNT_W'(BYTE_W)) begin
          shreg   <= {d_s, shreg[BYTE_W-1:1]};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end else if (!at_stop) begin
          par_q   <= d_s;
          bit_cnt <= bit_cnt + CNT_W'(1);
        end else begin
          bit_cnt <= '0;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign byte_o   = shreg;
  assign par_ok_o = odd_par_ok(shreg, par_q);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(LAST_BIT)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
  AST_BAD_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && at_stop && !d_s) |=> !done_q); // R9
endmodule

// File: rtl/kbd_out_buf.sv
module kbd_out_buf
  import kbd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_done,
  input  kbd_byte_t rx_byte,
  input  logic      rx_par_ok,
  input  logic      rd_data_evt,
  output kbd_byte_t obuf,
  output logic      obf,
  output logic      perr
);
  logic load_evt, drop_evt;
  assign load_evt = rx_done && (!obf || rd_data_evt);
  assign drop_evt = rx_done && !load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf <= '0;
      obf  <= 1'b0;
      perr <= 1'b0;
    end else if (load_evt) begin
      obuf <= rx_byte;
      obf  <= 1'b1;
      perr <= !rx_par_ok;
    end else if (rd_data_evt) begin
      obf  <= 1'b0;
    end
  end

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> obf && (obuf == $past(rx_byte))); // R5
  AST_RD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && !rx_done) |=> !obf); // R6
  AST_PERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !rx_par_ok) |=> perr); // R7
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(obuf) && $stable(perr)); // R8
  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && rx_done) |=> obf); // R10
endmodule

// File: rtl/kbd_in_buf.sv
module kbd_in_buf
  import kbd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic      sel_cmd,
  input  kbd_byte_t wdata,
  input  logic      ack,
  output kbd_byte_t ib_data,
  output logic      ib_full,
  output logic      ib_cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_data <= '0;
      ib_full <= 1'b0;
      ib_cmd  <= 1'b0;
    end else if (wr) begin
      ib_data <= wdata;
      ib_full <= 1'b1;
      ib_cmd  <= sel_cmd;
    end else if (ack) begin
      ib_full <= 1'b0;
    end
  end

  AST_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ib_full && (ib_cmd == $past(sel_cmd))); // R2 R3
  AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr) |=> !ib_full); // R4
endmodule

// File: rtl/kbd_host_if.sv
module kbd_host_if
  import kbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel_cmd,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq,
  input  logic       kb_clk,
  input  logic       kb_data,
  input  logic       ib_ack,
  output logic [7:0] ib_data,
  output logic       ib_is_cmd,
  output logic       ib_full
);
  logic      rx_done, rx_par_ok, rd_data_evt;
  kbd_byte_t rx_byte, obuf, status;
  logic      obf, perr;

  assign rd_data_evt = host_rd && !host_sel_cmd;

  kbd_rx_frame #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .kb_clk(kb_clk), .kb_data(kb_data),
    .done_o(rx_done), .byte_o(rx_byte), .par_ok_o(rx_par_ok)
  );

  kbd_out_buf u_ob (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .rx_par_ok(rx_par_ok), .rd_data_evt(rd_data_evt),
    .obuf(obuf), .obf(obf), .perr(perr)
  );

  kbd_in_buf u_ib (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel_cmd(host_sel_cmd),
    .wdata(host_wdata), .ack(ib_ack),
    .ib_data(ib_data), .ib_full(ib_full), .ib_cmd(ib_is_cmd)
  );

  assign status     = pack_status(obf, ib_full, ib_is_cmd, perr);
  assign host_rdata = host_sel_cmd ? status : obuf;
  assign irq        = obf;

  AST_STATUS_RD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel_cmd && !rx_done) |=> $stable(obf)); // R6
endmodule

// File: tb/kbd_host_if_tb.sv
module kbd_host_if_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_sel_cmd = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata, ib_data;
  logic       irq, kb_clk = 1'b1, kb_data = 1'b1, ib_ack = 1'b0;
  logic       ib_is_cmd, ib_full;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  kbd_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel_cmd(host_sel_cmd), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .kb_clk(kb_clk), .kb_data(kb_data), .ib_ack(ib_ack),
    .ib_data(ib_data), .ib_is_cmd(ib_is_cmd), .ib_full(ib_full)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d, input logic with_ack);
    @(negedge clk);
    host_wr = 1'b1; host_sel_cmd = sel; host_wdata = d; ib_ack = with_ack;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0; ib_ack = 1'b0; host_sel_cmd = 1'b0;
  endtask

  task automatic host_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_sel_cmd = sel;
    #1 v = host_rdata;
    @(posedge clk);
    @(negedge clk);
    host_rd = 1'b0; host_sel_cmd = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ib_ack = 1'b1;
    @(posedge clk);
    @(negedge clk); ib_ack = 1'b0;
  endtask

  task automatic kb_bit(input logic b);
    @(negedge clk); kb_data = b;
    repeat (4) @(negedge clk);
    kb_clk = 1'b0;
    repeat (8) @(negedge clk);
    kb_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // start, data LSB first, parity; stop bit sent separately
  task automatic kb_head(input logic [7:0] b, input logic bad_par);
    kb_bit(1'b0);
    for (int i = 0; i < 8; i++) kb_bit(b[i]);
    kb_bit((~^b) ^ bad_par);
  endtask

  task automatic kb_frame(input logic [7:0] b, input logic bad_par, input logic stop);
    kb_head(b, bad_par);
    kb_bit(stop);
    kb_data = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 ib_full", {7'b0, ib_full}, 8'h00);
    host_read(1'b1, v);
    check("R1 R11 status", v, 8'h00);
  endtask

  task automatic t_data_write();
    logic [7:0] v;
    host_write(1'b0, 8'h5A, 1'b0);
    check("R2 ib_data", ib_data, 8'h5A);
    check("R2 ib_full", {7'b0, ib_full}, 8'h01);
    check("R2 ib_is_cmd", {7'b0, ib_is_cmd}, 8'h00);
    host_read(1'b1, v);
    check("R11 status ibf", v, 8'h02);
  endtask

  task automatic t_cmd_write();
    logic [7:0] v;
    host_write(1'b1, 8'hAD, 1'b0);
    check("R3 ib_data", ib_data, 8'hAD);
    check("R3 ib_is_cmd", {7'b0, ib_is_cmd}, 8'h01);
    host_read(1'b1, v);
    check("R3 R11 status cmd", v, 8'h0A);
  endtask

  task automatic t_ack();
    pulse_ack();
    check("R4 ack clears", {7'b0, ib_full}, 8'h00);
    host_write(1'b0, 8'h3C, 1'b1);
    check("R4 write beats ack", {7'b0, ib_full}, 8'h01);
    check("R4 data", ib_data, 8'h3C);
    pulse_ack();
    check("R4 ack clears again", {7'b0, ib_full}, 8'h00);
  endtask

  task automatic t_rx_good();
    logic [7:0] v;
    kb_frame(8'h1C, 1'b0, 1'b1);
    check("R6 irq set", {7'b0, irq}, 8'h01);
    host_read(1'b1, v);
    check("R5 R11 status obf", v, 8'h01);
    check("R6 status read keeps irq", {7'b0, irq}, 8'h01);
    host_read(1'b0, v);
    check("R5 data", v, 8'h1C);
    check("R6 irq cleared", {7'b0, irq}, 8'h00);
    host_read(1'b1, v);
    check("R6 status empty", v, 8'h00);
  endtask

  task automatic t_rx_parerr();
    logic [7:0] v;
    kb_frame(8'h33, 1'b1, 1'b1);
    host_read(1'b1, v);
    check("R7 status perr", v, 8'h81);
    host_read(1'b0, v);
    check("R7 data kept", v, 8'h33);
    kb_frame(8'h44, 1'b0, 1'b1);
    host_read(1'b1, v);
    check("R7 perr cleared", v, 8'h01);
    host_read(1'b0, v);
    check("R7 good data", v, 8'h44);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    kb_frame(8'h11, 1'b0, 1'b1);
    kb_frame(8'h22, 1'b1, 1'b1);
    host_read(1'b1, v);
    check("R8 status unchanged", v, 8'h01);
    host_read(1'b0, v);
    check("R8 data kept", v, 8'h11);
  endtask

  task automatic t_bad_stop();
    logic [7:0] v;
    kb_frame(8'h77, 1'b0, 1'b0);
    host_read(1'b1, v);
    check("R9 dropped", v, 8'h00);
    check("R9 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    kb_frame(8'hA5, 1'b0, 1'b1);
    kb_head(8'h5C, 1'b0);
    @(negedge clk); kb_data = 1'b1;
    repeat (4) @(negedge clk);
    kb_clk = 1'b0;
    // two sync stages, edge register, done register: load in fourth clock
    repeat (3) @(posedge clk);
    @(negedge clk);
    host_rd = 1'b1; host_sel_cmd = 1'b0;
    #1 v = host_rdata;
    @(posedge clk);
    @(negedge clk);
    host_rd = 1'b0;
    check("R10 old byte returned", v, 8'hA5);
    check("R10 stays full", {7'b0, irq}, 8'h01);
    repeat (7) @(negedge clk);
    kb_clk = 1'b1;
    repeat (8) @(negedge clk);
    host_read(1'b0, v);
    check("R10 new byte", v, 8'h5C);
    host_read(1'b1, v);
    check("R10 empty after", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_data_write();
    t_cmd_write();
    t_ack();
    t_rx_good();
    t_rx_parerr();
    t_overrun();
    t_bad_stop();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule